// File: doc/BRIEF.md
# Iterative Restoring Unsigned Divider

This block divides one unsigned word by another over a fixed series of clock cycles, resolving a single quotient bit per cycle. A start pulse captures both operands. The dividend register is not shifted. A down-counter chooses which of its bits enters the partial remainder next, beginning with the most significant bit. On every step the partial remainder moves left by one place and the chosen dividend bit fills the vacated low bit. A single magnitude comparison against the divisor then does two jobs. It selects whether the divisor is subtracted, and it supplies the new low bit that is shifted into the quotient.

Control is a three-state machine. `ST_IDLE` waits for `start`. The transition `ST_IDLE -> ST_RUN` happens on `start`, and it loads the operands, clears the remainder and quotient, and sets the counter to the top bit index. `ST_RUN` performs one iteration per cycle. It stays in `ST_RUN` while the counter is non-zero, and it takes `ST_RUN -> ST_FIN` once the bit-0 iteration completes. `ST_FIN` raises `done` for exactly one cycle and always returns with `ST_FIN -> ST_IDLE`. The results stay on the outputs until the next accepted start. A zero divisor produces no special datapath behaviour. The ordinary algorithm already yields a quotient of all ones and a remainder equal to the dividend, and a flag captured at load time marks the case alongside `done`.

Top module: `div_restoring`

## Requirements
- R1: After reset, `done` and `div_by_zero` are 0 and `quotient` and `remainder` are 0.
- R2: A `start` sampled high in `ST_IDLE` is accepted, and `done` is high in the 33rd cycle after the accepting clock edge (WIDTH iterations plus one finish cycle).
- R3: At `done`, `quotient` equals floor(dividend / divisor) for the operands captured at the accepted start, with divisor non-zero.
- R4: At `done`, `remainder` equals dividend mod divisor and is less than the divisor, with divisor non-zero.
- R5: `done` is a single-cycle pulse.
- R6: After `done`, `quotient` and `remainder` hold their values until the next accepted start, even when the operand inputs change.
- R7: A `start` pulse while an operation is in progress (`ST_RUN` or `ST_FIN`) is ignored, and the result reflects the originally captured operands.
- R8: With a divisor of 0, `div_by_zero` is 1 in the same cycle as `done`, `quotient` is all ones, and `remainder` equals the dividend.
- R9: `div_by_zero` is 0 whenever `done` is 0, and it is 0 at `done` for a non-zero divisor.
- R10: 45 divided by 3 gives quotient 15 and remainder 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a division when the block is idle |
| dividend | input | WIDTH | Numerator, captured on an accepted start |
| divisor | input | WIDTH | Denominator, captured on an accepted start |
| quotient | output | WIDTH | Integer quotient |
| remainder | output | WIDTH | Remainder |
| done | output | 1 | One-cycle pulse when results are ready |
| div_by_zero | output | 1 | High with `done` when the captured divisor was zero |

## Verification
The vector table pairs operands chosen to separate specific faults. A divisor larger than the dividend forces every comparison false. A divisor equal to the dividend succeeds only on the final bit. A divisor of one and an all-ones dividend make every comparison true. A top-bit-only divisor tests the widest compare, and a power-of-two divisor shows whether the bit selection and remainder alignment match. The directed tests then run a zero divisor, a start issued in the middle of a run, and a change of operand inputs after completion. Together these check the subtract-free path, the flag, and the idle-only acceptance of `start`.

// File: rtl/div_pkg.sv
package div_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } div_state_t;
endpackage

// File: rtl/div_ctrl.sv
module div_ctrl
    import div_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int CNT_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             load,
    output logic             step,
    output logic             fin,
    output logic             busy,
    output logic [CNT_W-1:0] bit_idx
);
    localparam logic [CNT_W-1:0] TOP_IDX = CNT_W'(WIDTH - 1);

    div_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // next-state function
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (cnt_q == '0) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state and counter registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) cnt_q <= TOP_IDX;
            else if (state_q == ST_RUN)      cnt_q <= cnt_q - 1'b1;
        end
    end

    // output function
    always_comb begin
        load    = 1'b0;
        step    = 1'b0;
        fin     = 1'b0;
        busy    = 1'b1;
        bit_idx = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                load = start;
                busy = 1'b0;
            end
            ST_RUN:  step = 1'b1;
            ST_FIN:  fin  = 1'b1;
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/div_datapath.sv
module div_datapath #(
    parameter int WIDTH = 32,
    localparam int CNT_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [CNT_W-1:0] bit_idx,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder,
    output logic             zero_div
);
    logic [WIDTH-1:0] num_q, den_q, rem_q, quo_q;
    logic             zdiv_q;
    logic [WIDTH:0]   shifted;
    logic [WIDTH:0]   diff;
    logic             fits;

    // shift partial remainder, append the selected dividend bit
    always_comb begin
        shifted = {rem_q, num_q[bit_idx]};
        fits    = shifted >= {1'b0, den_q};
        diff    = shifted - {1'b0, den_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            num_q  <= '0;
            den_q  <= '0;
            rem_q  <= '0;
            quo_q  <= '0;
            zdiv_q <= 1'b0;
        end else if (load) begin
            num_q  <= dividend;
            den_q  <= divisor;
            rem_q  <= '0;
            quo_q  <= '0;
            zdiv_q <= (divisor == '0);
        end else if (step) begin
            rem_q <= fits ? diff[WIDTH-1:0] : shifted[WIDTH-1:0];
            quo_q <= {quo_q[WIDTH-2:0], fits};
        end
    end

    assign quotient  = quo_q;
    assign remainder = rem_q;
    assign zero_div  = zdiv_q;
endmodule

// File: rtl/div_restoring.sv
module div_restoring #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder,
    output logic             done,
    output logic             div_by_zero
);
    localparam int CNT_W = $clog2(WIDTH);

    logic             load, step, fin, busy, zero_div;
    logic [CNT_W-1:0] bit_idx;

    div_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .load    (load),
        .step    (step),
        .fin     (fin),
        .busy    (busy),
        .bit_idx (bit_idx)
    );

    div_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .bit_idx   (bit_idx),
        .dividend  (dividend),
        .divisor   (divisor),
        .quotient  (quotient),
        .remainder (remainder),
        .zero_div  (zero_div)
    );

    assign done        = fin;
    assign div_by_zero = fin & zero_div;
endmodule

// File: rtl/div_checker.sv
module div_checker #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic [WIDTH-1:0] dividend,
    input logic [WIDTH-1:0] divisor,
    input logic [WIDTH-1:0] quotient,
    input logic [WIDTH-1:0] remainder,
    input logic             done,
    input logic             div_by_zero
);
    localparam int SW = $clog2(WIDTH) + 2;
    localparam logic [SW-1:0] SMAX = '1;

    logic             accept;
    logic [SW-1:0]    since;
    logic [WIDTH-1:0] op_a, op_b;

    assign accept = start && !busy;

    // operands captured and cycles counted from the accepting edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since <= '0;
            op_a  <= '0;
            op_b  <= '0;
        end else if (accept) begin
            since <= SW'(1);
            op_a  <= dividend;
            op_b  <= divisor;
        end else if (since != '0 && since != SMAX) begin
            since <= since + 1'b1;
        end
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> since == SW'(WIDTH + 1));

    p_quotient_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_b != '0) |-> quotient == op_a / op_b);

    p_remainder_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_b != '0) |-> (remainder == op_a % op_b) && (remainder < op_b));

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(quotient) && $stable(remainder)));

    p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_b == '0) |-> (div_by_zero && quotient == '1 && remainder == op_a));

    p_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        div_by_zero |-> (done && op_b == '0));
endmodule

bind div_restoring div_checker #(.WIDTH(WIDTH)) u_div_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .dividend    (dividend),
    .divisor     (divisor),
    .quotient    (quotient),
    .remainder   (remainder),
    .done        (done),
    .div_by_zero (div_by_zero)
);

// File: tb/test_div_restoring.sv
module test_div_restoring;
    localparam int W = 32;
    localparam int NV = 9;

    // {dividend, divisor, quotient, remainder}
    localparam logic [4*W-1:0] VEC [NV] = '{
        {32'd45,         32'd3,          32'd15,         32'd0},
        {32'd100,        32'd7,          32'd14,         32'd2},
        {32'hFFFF_FFFF,  32'd1,          32'hFFFF_FFFF,  32'd0},
        {32'hFFFF_FFFF,  32'hFFFF_FFFF,  32'd1,          32'd0},
        {32'd5,          32'd9,          32'd0,          32'd5},
        {32'h8000_0000,  32'd2,          32'h4000_0000,  32'd0},
        {32'd1000000,    32'd1000,       32'd1000,       32'd0},
        {32'hDEAD_BEEF,  32'h10,         32'h0DEA_DBEE,  32'hF},
        {32'h1234_5678,  32'h8000_0000,  32'd0,          32'h1234_5678}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0, divisor = '0;
    logic [W-1:0] quotient, remainder;
    logic         done, div_by_zero;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    div_restoring #(.WIDTH(W)) i_div_restoring (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dividend(dividend), .divisor(divisor),
        .quotient(quotient), .remainder(remainder),
        .done(done), .div_by_zero(div_by_zero)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // start at a negedge; optionally inject a start mid-run with other operands
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          input bit poke, output bit done_ok);
        logic early;
        @(negedge clk);
        dividend = a; divisor = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        early = 1'b0;
        for (int k = 1; k <= 32; k++) begin
            if (poke && k == 10) begin
                dividend = 32'd7; divisor = 32'd2; start = 1'b1;
            end
            if (poke && k == 11) start = 1'b0;
            @(negedge clk);
            if (k < 32 && done) early = 1'b1;
        end
        done_ok = done && !early;
    endtask

    initial begin
        bit ok;
        logic [W-1:0] hq, hr;
        #9;
        check("R1 done", W'(done), '0);
        check("R1 quotient", quotient, '0);
        check("R1 remainder", remainder, '0);
        check("R1 div_by_zero", W'(div_by_zero), '0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [W-1:0] a, b, eq, er;
            {a, b, eq, er} = VEC[i];
            run_op(a, b, 1'b0, ok);
            check("R2 done timing", W'(ok), W'(1));
            check("R3 quotient", quotient, eq);
            check("R4 remainder", remainder, er);
            check("R3 quotient vs arithmetic", quotient, a / b);
            check("R9 flag low", W'(div_by_zero), '0);
            if (i == 0) begin
                check("R10 45/3 quotient", quotient, 32'd15);
                check("R10 45/3 remainder", remainder, 32'd0);
            end
            @(negedge clk);
            check("R5 done pulse", W'(done), '0);
        end

        // R6: inputs change without start, results hold
        hq = quotient; hr = remainder;
        dividend = 32'h5555_5555; divisor = 32'd3;
        repeat (5) @(negedge clk);
        check("R6 quotient hold", quotient, hq);
        check("R6 remainder hold", remainder, hr);
        check("R9 flag low idle", W'(div_by_zero), '0);

        // R8: zero divisor
        run_op(32'hCAFE_1234, 32'd0, 1'b0, ok);
        check("R8 done timing", W'(ok), W'(1));
        check("R8 flag", W'(div_by_zero), W'(1));
        check("R8 quotient ones", quotient, '1);
        check("R8 remainder", remainder, 32'hCAFE_1234);
        @(negedge clk);
        check("R9 flag drops", W'(div_by_zero), '0);

        // R7: start during a run is ignored
        run_op(32'd1000, 32'd7, 1'b1, ok);
        check("R7 done timing", W'(ok), W'(1));
        check("R7 quotient", quotient, 32'd142);
        check("R7 remainder", remainder, 32'd6);
        @(negedge clk);
        check("R7 no second op", W'(done), '0);
        repeat (40) @(negedge clk);
        check("R7 no late done", W'(done), '0);
        check("R7 result kept", quotient, 32'd142);

        finished = 1'b1;
    end

    initial begin
        int n = 0;
        while (!finished && n < 100000) begin
            @(posedge clk);
            n++;
        end
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule